// File: doc/BRIEF.md
# EDO DRAM Bus Cycle Classifier

This block watches the control strobes of an EDO DRAM interface: row strobe, upper and lower column strobes, write enable and output enable, all active low. It samples them with the block clock, which is much faster than the strobes change. It decides what kind of memory cycle each row-strobe-low period was. When the row strobe returns high, the block reports a 4-bit cycle code, a per-byte write mask and a one-cycle valid pulse. It also keeps sticky error flags for protocol misuse. An external clear input resets those flags.

The pins first pass through a two-stage synchroniser and then an edge detector. The classifier looks only at the order of the strobe edges. The column mode is defined by the OR of the two byte strobes: it starts at whichever byte strobe falls first and ends at whichever rises last. Write timing is still tracked for each byte. Duration limits for refresh cycles are parameters counted in sample clocks.

Top module: `edo_cycle_classifier`

## Requirements
- R1: After reset, `cyc_valid` is 0, `cyc_code` is 0 (standby), `cyc_wmask` is 0 and all three error flags are 0.
- R2: With two synchroniser stages, `cyc_valid` pulses for exactly one clock, on the third rising clock edge after the row-strobe pin returns high. `cyc_code` and `cyc_wmask` change only with that pulse and hold their value until the next report.
- R3: If either column strobe is low when the row strobe falls, the cycle is column-before-row refresh, code 6, with write mask 0.
- R4: If neither column strobe falls during the row-low period, the cycle is row-only refresh, code 5, with write mask 0.
- R5: A cycle with one column period and write enable high throughout is a read, code 1.
- R6: If write enable is already low when a byte strobe falls, that byte is written early, and the cycle is early write, code 2.
- R7: If write enable falls while a column strobe is low, and no read was seen in that column period, the cycle is delayed write, code 3.
- R8: If output enable was low while a column strobe was low and write enable high, and write enable falls later in the same column period, the cycle is read-modify-write, code 4.
- R9: Two or more falling edges of the OR of the column strobes within one row-low period make the cycle page mode, code 8. Page mode takes precedence over all write kinds. Among the rest the precedence is early write, then read-modify-write, then delayed write, then read.
- R10: Write mask bit 0 is the lower byte and bit 1 the upper byte. A byte whose strobe stays high during the cycle is not marked as written.
- R11: A column-before-row cycle whose row-low length reaches `SELF_MIN` samples is self-refresh, code 7, with no error. A length of at least `FORBID_MIN` but below `SELF_MIN` gives code 6 and sets `err_forbidden_len`.
- R12: `err_skew` is set when, in a normal (not refresh) cycle, one byte strobe falls while the other byte strobe is already low.
- R13: `err_mixed_write` is set at the report when, within one row-low period, one byte was written early and the other byte was written late.
- R14: The error flags are sticky. `clr_err` clears them, and a new error event in the same clock wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_err | input | 1 | Clears the sticky error flags |
| ras_n_pin | input | 1 | Row strobe pin, active low, asynchronous |
| ucas_n_pin | input | 1 | Upper byte column strobe pin, active low |
| lcas_n_pin | input | 1 | Lower byte column strobe pin, active low |
| we_n_pin | input | 1 | Write enable pin, active low |
| oe_n_pin | input | 1 | Output enable pin, active low |
| cyc_valid | output | 1 | One-cycle report strobe |
| cyc_code | output | 4 | Cycle type code |
| cyc_wmask | output | 2 | Bytes written in the reported cycle |
| err_skew | output | 1 | Sticky byte-strobe skew flag |
| err_mixed_write | output | 1 | Sticky mixed write-mode flag |
| err_forbidden_len | output | 1 | Sticky forbidden refresh-length flag |

## Verification
The bench builds the block with `FORBID_MIN` = 40 and `SELF_MIN` = 100 samples and keeps two synchroniser stages. With these values, both the forbidden refresh length window and self-refresh entry occur within a few hundred clocks, so each side of both thresholds is exercised. The default values correspond to real microsecond durations at a fast clock and would make those cases far too long to simulate.

// File: rtl/edo_cls_pkg.sv
package edo_cls_pkg;
  localparam int NPIN    = 5;
  localparam int P_RAS   = 0;
  localparam int P_UCAS  = 1;
  localparam int P_LCAS  = 2;
  localparam int P_WE    = 3;
  localparam int P_OE    = 4;

  localparam logic [3:0] K_STANDBY = 4'd0;
  localparam logic [3:0] K_READ    = 4'd1;
  localparam logic [3:0] K_EARLYWR = 4'd2;
  localparam logic [3:0] K_LATEWR  = 4'd3;
  localparam logic [3:0] K_RMW     = 4'd4;
  localparam logic [3:0] K_ROWREF  = 4'd5;
  localparam logic [3:0] K_CBR     = 4'd6;
  localparam logic [3:0] K_SELF    = 4'd7;
  localparam logic [3:0] K_PAGE    = 4'd8;
endpackage

// File: rtl/edo_pin_sync.sv
module edo_pin_sync #(
  parameter int W = 5,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stg[gi] <= RST_VAL;
        else if (gi == 0) stg[gi] <= d;
        else stg[gi] <= stg[(gi == 0) ? 0 : gi - 1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/edo_edge_det.sv
module edo_edge_det #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] act,
  output logic [W-1:0] on,
  output logic [W-1:0] off
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= act;
  end

  assign on  = act & ~prev_q;
  assign off = prev_q & ~act;
endmodule

// File: rtl/edo_cycle_tracker.sv
module edo_cycle_tracker
  import edo_cls_pkg::*;
#(
  parameter int FORBID_MIN = 1000,
  parameter int SELF_MIN   = 10000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] lvl,
  input  logic [NPIN-1:0] on,
  input  logic [NPIN-1:0] off,
  output logic            valid,
  output logic [3:0]      code,
  output logic [1:0]      wmask,
  output logic            ev_skew,
  output logic            ev_mixed,
  output logic            ev_forbid
);
  localparam int LW = $clog2(SELF_MIN + 1);
  localparam logic [LW-1:0] FMIN = LW'(FORBID_MIN);
  localparam logic [LW-1:0] SMIN = LW'(SELF_MIN);

  logic          in_ras_q, cbr_q, rmw_q, dly_q, oe_seen_q;
  logic [1:0]    falls_q, early_q, late_q;
  logic [LW-1:0] len_q;

  logic [1:0] byte_lvl, byte_on, byte_prev;
  logic       any_on, normal, skew_now, ras_end;
  logic [3:0] next_code;
  logic       unused_edges;

  assign byte_lvl  = {lvl[P_UCAS], lvl[P_LCAS]};
  assign byte_on   = {on[P_UCAS], on[P_LCAS]};
  assign byte_prev = (byte_lvl & ~byte_on) | {off[P_UCAS], off[P_LCAS]};
  assign any_on    = (|byte_lvl) & ~(|byte_prev);
  assign normal    = in_ras_q & ~cbr_q;
  assign ras_end   = in_ras_q & off[P_RAS];
  assign skew_now  = normal & ((byte_on[0] & byte_lvl[1] & ~byte_on[1]) |
                               (byte_on[1] & byte_lvl[0] & ~byte_on[0]));
  assign unused_edges = ^{lvl[P_RAS], on[P_OE], off[P_WE], off[P_OE]};

  always_comb begin
    if (cbr_q)                 next_code = (len_q >= SMIN) ? K_SELF : K_CBR;
    else if (falls_q == 2'd0)  next_code = K_ROWREF;
    else if (falls_q == 2'd2)  next_code = K_PAGE;
    else if (|early_q)         next_code = K_EARLYWR;
    else if (rmw_q)            next_code = K_RMW;
    else if (dly_q)            next_code = K_LATEWR;
    else                       next_code = K_READ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_ras_q  <= 1'b0;
      cbr_q     <= 1'b0;
      rmw_q     <= 1'b0;
      dly_q     <= 1'b0;
      oe_seen_q <= 1'b0;
      falls_q   <= '0;
      early_q   <= '0;
      late_q    <= '0;
      len_q     <= '0;
      valid     <= 1'b0;
      code      <= K_STANDBY;
      wmask     <= '0;
      ev_skew   <= 1'b0;
      ev_mixed  <= 1'b0;
      ev_forbid <= 1'b0;
    end else begin
      valid     <= 1'b0;
      ev_skew   <= skew_now;
      ev_mixed  <= 1'b0;
      ev_forbid <= 1'b0;
      if (on[P_RAS]) begin
        in_ras_q  <= 1'b1;
        cbr_q     <= |byte_lvl;
        rmw_q     <= 1'b0;
        dly_q     <= 1'b0;
        oe_seen_q <= 1'b0;
        falls_q   <= '0;
        early_q   <= '0;
        late_q    <= '0;
        len_q     <= LW'(1);
      end else if (in_ras_q) begin
        if (len_q < SMIN) len_q <= len_q + LW'(1);
        if (normal) begin
          if (any_on) begin
            if (falls_q != 2'd2) falls_q <= falls_q + 2'd1;
            oe_seen_q <= 1'b0;
          end else if ((|byte_lvl) & lvl[P_OE] & ~lvl[P_WE]) begin
            oe_seen_q <= 1'b1;
          end
          early_q <= early_q | (byte_on & {2{lvl[P_WE]}});
          if (on[P_WE]) begin
            late_q <= late_q | byte_lvl;
            if (|byte_lvl) begin
              if (oe_seen_q) rmw_q <= 1'b1;
              else           dly_q <= 1'b1;
            end
          end
        end
        if (ras_end) begin
          in_ras_q  <= 1'b0;
          valid     <= 1'b1;
          code      <= next_code;
          wmask     <= cbr_q ? 2'b00 : (early_q | late_q);
          ev_mixed  <= ~cbr_q & ((early_q[0] & late_q[1]) | (early_q[1] & late_q[0]));
          ev_forbid <= cbr_q & (len_q >= FMIN) & (len_q < SMIN);
        end
      end
    end
  end
endmodule

// File: rtl/edo_cycle_classifier.sv
module edo_cycle_classifier
  import edo_cls_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FORBID_MIN  = 1000,
  parameter int SELF_MIN    = 10000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr_err,
  input  logic       ras_n_pin,
  input  logic       ucas_n_pin,
  input  logic       lcas_n_pin,
  input  logic       we_n_pin,
  input  logic       oe_n_pin,
  output logic       cyc_valid,
  output logic [3:0] cyc_code,
  output logic [1:0] cyc_wmask,
  output logic       err_skew,
  output logic       err_mixed_write,
  output logic       err_forbidden_len
);
  logic [NPIN-1:0] pins_n, sync_n, act, on, off;
  logic ev_skew, ev_mixed, ev_forbid;

  assign pins_n = {oe_n_pin, we_n_pin, lcas_n_pin, ucas_n_pin, ras_n_pin};

  edo_pin_sync #(.W(NPIN), .STAGES(SYNC_STAGES), .RST_VAL('1)) i_sync (
    .clk(clk), .rst(rst), .d(pins_n), .q(sync_n)
  );

  assign act = ~sync_n;

  edo_edge_det #(.W(NPIN)) i_edge (
    .clk(clk), .rst(rst), .act(act), .on(on), .off(off)
  );

  edo_cycle_tracker #(.FORBID_MIN(FORBID_MIN), .SELF_MIN(SELF_MIN)) i_track (
    .clk(clk), .rst(rst), .lvl(act), .on(on), .off(off),
    .valid(cyc_valid), .code(cyc_code), .wmask(cyc_wmask),
    .ev_skew(ev_skew), .ev_mixed(ev_mixed), .ev_forbid(ev_forbid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      err_skew          <= 1'b0;
      err_mixed_write   <= 1'b0;
      err_forbidden_len <= 1'b0;
    end else begin
      if (ev_skew)        err_skew <= 1'b1;
      else if (clr_err)   err_skew <= 1'b0;
      if (ev_mixed)       err_mixed_write <= 1'b1;
      else if (clr_err)   err_mixed_write <= 1'b0;
      if (ev_forbid)      err_forbidden_len <= 1'b1;
      else if (clr_err)   err_forbidden_len <= 1'b0;
    end
  end
endmodule

// File: rtl/edo_cls_checker.sv
module edo_cls_checker
  import edo_cls_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       clr_err,
  input logic       cyc_valid,
  input logic [3:0] cyc_code,
  input logic [1:0] cyc_wmask,
  input logic       err_skew,
  input logic       err_mixed_write,
  input logic       err_forbidden_len
);
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
    cyc_valid |=> !cyc_valid);

  a_r2_code_held: assert property (@(posedge clk) disable iff (rst)
    !$stable(cyc_code) |-> cyc_valid);

  a_r2_code_legal: assert property (@(posedge clk) disable iff (rst)
    cyc_valid |-> (cyc_code != K_STANDBY && cyc_code <= K_PAGE));

  a_r10_refresh_no_mask: assert property (@(posedge clk) disable iff (rst)
    (cyc_valid && (cyc_code == K_ROWREF || cyc_code == K_CBR || cyc_code == K_SELF))
      |-> cyc_wmask == 2'b00);

  a_r14_skew_sticky: assert property (@(posedge clk) disable iff (rst)
    (err_skew && !clr_err) |=> err_skew);

  a_r14_mixed_sticky: assert property (@(posedge clk) disable iff (rst)
    (err_mixed_write && !clr_err) |=> err_mixed_write);

  a_r14_forbid_sticky: assert property (@(posedge clk) disable iff (rst)
    (err_forbidden_len && !clr_err) |=> err_forbidden_len);

  a_r14_skew_clear_only: assert property (@(posedge clk) disable iff (rst)
    $fell(err_skew) |-> $past(clr_err));

  a_r14_forbid_clear_only: assert property (@(posedge clk) disable iff (rst)
    $fell(err_forbidden_len) |-> $past(clr_err));
endmodule

bind edo_cycle_classifier edo_cls_checker i_chk (
  .clk(clk), .rst(rst), .clr_err(clr_err),
  .cyc_valid(cyc_valid), .cyc_code(cyc_code), .cyc_wmask(cyc_wmask),
  .err_skew(err_skew), .err_mixed_write(err_mixed_write),
  .err_forbidden_len(err_forbidden_len)
);

// File: tb/test_edo_cycle_classifier.sv
`timescale 1ns/1ps
module test_edo_cycle_classifier;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clr_err = 1'b0;
  logic ras_n = 1'b1, ucas_n = 1'b1, lcas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic       cyc_valid;
  logic [3:0] cyc_code;
  logic [1:0] cyc_wmask;
  logic       err_skew, err_mixed_write, err_forbidden_len;
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  edo_cycle_classifier #(.SYNC_STAGES(2), .FORBID_MIN(40), .SELF_MIN(100)) i_edo_cycle_classifier (
    .clk(clk), .rst(rst), .clr_err(clr_err),
    .ras_n_pin(ras_n), .ucas_n_pin(ucas_n), .lcas_n_pin(lcas_n),
    .we_n_pin(we_n), .oe_n_pin(oe_n),
    .cyc_valid(cyc_valid), .cyc_code(cyc_code), .cyc_wmask(cyc_wmask),
    .err_skew(err_skew), .err_mixed_write(err_mixed_write),
    .err_forbidden_len(err_forbidden_len)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic expect_report(input string req, input int code, input int mask);
    bit seen = 1'b0;
    for (int i = 0; i < 20 && !seen; i++) begin
      tick(1);
      if (cyc_valid) seen = 1'b1;
    end
    chk({req, " report seen"}, int'(seen), 1);
    chk({req, " code"}, int'(cyc_code), code);
    chk({req, " mask"}, int'(cyc_wmask), mask);
    tick(4);
  endtask

  task automatic clear_errors();
    clr_err = 1'b1; tick(1); clr_err = 1'b0; tick(1);
  endtask

  task automatic t_reset();
    chk("R1 valid", int'(cyc_valid), 0);
    chk("R1 code", int'(cyc_code), 0);
    chk("R1 mask", int'(cyc_wmask), 0);
    chk("R1 errors", int'({err_skew, err_mixed_write, err_forbidden_len}), 0);
  endtask

  task automatic t_read_latency();
    ras_n = 0; tick(2); ucas_n = 0; lcas_n = 0; tick(3);
    ucas_n = 1; lcas_n = 1; tick(2);
    ras_n = 1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R2 not early", int'(cyc_valid), 0);
    @(posedge clk); @(negedge clk);
    chk("R2 valid on third edge", int'(cyc_valid), 1);
    chk("R5 read code", int'(cyc_code), 1);
    chk("R5 read mask", int'(cyc_wmask), 0);
    tick(1);
    chk("R2 single pulse", int'(cyc_valid), 0);
    chk("R2 code held", int'(cyc_code), 1);
    tick(4);
  endtask

  task automatic t_early_word();
    we_n = 0; tick(2); ras_n = 0; tick(2); ucas_n = 0; lcas_n = 0; tick(3);
    ucas_n = 1; lcas_n = 1; tick(2); ras_n = 1; tick(1); we_n = 1;
    expect_report("R6 early word", 2, 3);
  endtask

  task automatic t_early_lower();
    we_n = 0; tick(2); ras_n = 0; tick(2); lcas_n = 0; tick(3);
    lcas_n = 1; tick(2); ras_n = 1; tick(1); we_n = 1;
    expect_report("R10 lower byte only", 2, 1);
  endtask

  task automatic t_delayed();
    ras_n = 0; tick(2); ucas_n = 0; lcas_n = 0; tick(3); we_n = 0; tick(3);
    ucas_n = 1; lcas_n = 1; tick(2); we_n = 1; tick(2); ras_n = 1;
    expect_report("R7 delayed write", 3, 3);
  endtask

  task automatic t_rmw();
    ras_n = 0; tick(2); ucas_n = 0; tick(2); oe_n = 0; tick(3); oe_n = 1; tick(2);
    we_n = 0; tick(3); ucas_n = 1; tick(2); we_n = 1; tick(2); ras_n = 1;
    expect_report("R8 rmw upper", 4, 2);
  endtask

  task automatic t_row_only();
    ras_n = 0; tick(6); ras_n = 1;
    expect_report("R4 row only", 5, 0);
  endtask

  task automatic t_cbr(input int hold, input int code, input string req);
    lcas_n = 0; tick(2); ras_n = 0; tick(hold); ras_n = 1;
    expect_report(req, code, 0);
    lcas_n = 1; tick(3);
  endtask

  task automatic t_page();
    ras_n = 0; tick(2);
    for (int k = 0; k < 3; k++) begin
      ucas_n = 0; lcas_n = 0; tick(2); ucas_n = 1; lcas_n = 1; tick(2);
    end
    ras_n = 1;
    expect_report("R9 page read", 8, 0);
  endtask

  task automatic t_skew();
    chk("R12 clean before", int'(err_skew), 0);
    ras_n = 0; tick(2); ucas_n = 0; tick(2); lcas_n = 0; tick(3);
    ucas_n = 1; lcas_n = 1; tick(2); ras_n = 1;
    expect_report("R12 skewed read", 1, 0);
    chk("R12 skew flag", int'(err_skew), 1);
    tick(10);
    chk("R14 skew sticky", int'(err_skew), 1);
    clear_errors();
    chk("R14 skew cleared", int'(err_skew), 0);
  endtask

  task automatic t_mixed();
    we_n = 0; tick(2); ras_n = 0; tick(2); lcas_n = 0; tick(2); lcas_n = 1; tick(2);
    we_n = 1; tick(2); ucas_n = 0; tick(2); we_n = 0; tick(2); ucas_n = 1; tick(2);
    we_n = 1; tick(2); ras_n = 1;
    expect_report("R13 mixed page", 8, 3);
    chk("R13 mixed flag", int'(err_mixed_write), 1);
    chk("R13 no skew", int'(err_skew), 0);
    clear_errors();
    chk("R14 mixed cleared", int'(err_mixed_write), 0);
  endtask

  initial begin
    tick(5);
    rst = 1'b0;
    tick(2);
    t_reset();
    t_read_latency();
    t_early_word();
    t_early_lower();
    t_delayed();
    t_rmw();
    t_row_only();
    t_cbr(10, 6, "R3 cbr short");
    chk("R3 no forbid error", int'(err_forbidden_len), 0);
    t_cbr(60, 6, "R11 cbr forbidden window");
    chk("R11 forbid flag", int'(err_forbidden_len), 1);
    clear_errors();
    chk("R14 forbid cleared", int'(err_forbidden_len), 0);
    t_cbr(150, 7, "R11 self refresh");
    chk("R11 self no error", int'(err_forbidden_len), 0);
    t_page();
    t_skew();
    t_mixed();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule